// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is the bus-facing half of an I2C master. A processor-side sequencer hands it one command at a time: generate a start, generate a repeated start, generate a stop, shift a byte out, clock a byte in, or send the ninth-bit acknowledge after a received byte. The block builds SCL and every SDA transition itself and drives both open-drain lines low only, leaving a released line to the external pull-up. It samples the slave acknowledge after each transmitted byte and holds the last received byte.

Commands are never queued. Only one operation runs at a time. `busy` is high while one is in progress and falls when the engine completes it. In that same cycle a sticky interrupt flag is set. A transmit-buffer write that cannot start at once is thrown away and sets a sticky collision flag. Two status bits follow the bus: "start seen" and "stop seen". They are updated by a start/stop detector on the synchronised lines, or directly by the engine while it is generating its own conditions. A new start is only taken when the bus is free. Software builds 7-bit and 10-bit address bytes itself.

Top module: `i2c_master_ctrl`

## Requirements
- R1: After reset, and in any cycle after `enable` has been low, both line drivers are released. `busy`, `start_seen` and `stop_seen` are 0, and commands are ignored. Reset also clears `irq` and `wcol`.
- R2: Every SCL half-period generated by the block lasts `baud_reload`+1 clock cycles. `baud_reload` must be at least 3.
- R3: A start command pulls SDA low while SCL is high, then pulls SCL low one half-period later. On completion `busy` falls, `irq` is set, `start_seen`=1 and `stop_seen`=0.
- R4: A buffer write sends 8 bits, most significant first, changing SDA only while SCL is low. On the ninth clock SDA is released and the line level is stored in `ack_status` (0 = ACK, 1 = NACK). Completion sets `irq`.
- R5: A receive command releases SDA and generates 8 clocks. It samples SDA at the end of each high half, most significant bit first. The byte appears on `rx_data` when `busy` falls, and `irq` is set.
- R6: An acknowledge command generates one clock. During it SDA is low when `ack_nack` was 0 at the command, and released when it was 1. Completion sets `irq`.
- R7: A restart command releases SDA, raises SCL, then pulls SDA low while SCL is high, with no stop in between. It ends with `start_seen`=1, `stop_seen`=0 and `irq` set.
- R8: A stop command pulls SDA low, raises SCL, then releases SDA while SCL is high. It ends with `stop_seen`=1, `start_seen`=0 and `irq` set.
- R9: A buffer write is dropped and sets `wcol` in two cases: an operation is running, or a start, restart or stop command arrives in the same cycle. A dropped write does not alter the byte in flight, and nothing runs after the current operation. Other commands issued while `busy` is high are ignored.
- R10: `irq` stays set until `irq_clr` is pulsed, and `wcol` stays set until `wcol_clr` is pulsed. A set event in the same cycle wins over the clear.
- R11: A start or stop made by another bus agent sets `start_seen` or `stop_seen`, and clears the other bit. While `start_seen` is 1 and `stop_seen` is 0, a start command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low releases the bus and clears the status bits |
| baud_reload | input | BAUD_W | SCL half-period minus one, in clocks |
| cmd_start | input | 1 | Generate a start condition |
| cmd_restart | input | 1 | Generate a repeated start |
| cmd_stop | input | 1 | Generate a stop condition |
| cmd_rx | input | 1 | Receive one byte |
| cmd_ack | input | 1 | Send the acknowledge bit |
| ack_nack | input | 1 | Acknowledge level: 0 = ACK, 1 = NACK |
| tx_wr | input | 1 | Transmit buffer write; starts a byte transfer |
| tx_data | input | 8 | Byte to transmit |
| irq_clr | input | 1 | Clears the interrupt flag |
| wcol_clr | input | 1 | Clears the collision flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | An operation is in progress |
| irq | output | 1 | Sticky operation-complete flag |
| wcol | output | 1 | Sticky write-collision flag |
| ack_status | output | 1 | Acknowledge level sampled after the last transmitted byte |
| rx_data | output | 8 | Last received byte |
| start_seen | output | 1 | A start was last seen on the bus |
| stop_seen | output | 1 | A stop was last seen on the bus |

## Verification
The bench drives the block against a bus slave model with a pull-up, and goes after the points where the ordering of SDA and SCL edges matters. It counts the start and stop conditions the slave observes. A data bit that moved while SCL was high would show up as an extra condition, and a restart that lets a stop slip through would raise the stop count. It writes the buffer during a running start and during a running byte. An engine that queued the write would clock out an extra byte after `busy` fell, and one that loaded the buffer would corrupt the byte in flight. It also fakes another master's start to show that a start command is refused while the bus is owned, and it runs a 10-bit read with a restart to show that the read direction flips only after the repeated start.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int STEP_W = 5;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_START,
        OP_RESTART,
        OP_STOP,
        OP_TX,
        OP_RX,
        OP_ACK
    } op_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } drive_t;

    // index of the final half-period of each operation
    function automatic logic [STEP_W-1:0] op_last_step(op_e op);
        case (op)
            OP_START:   return STEP_W'(1);
            OP_RESTART: return STEP_W'(3);
            OP_STOP:    return STEP_W'(2);
            OP_TX:      return STEP_W'(2 * (BYTE_W + 1) - 1);
            OP_RX:      return STEP_W'(2 * BYTE_W - 1);
            OP_ACK:     return STEP_W'(1);
            default:    return '0;
        endcase
    endfunction

    // line drive for one half-period of an operation
    function automatic drive_t op_drive(op_e op, logic [STEP_W-1:0] step,
                                        logic [BYTE_W-1:0] sh, logic ackv);
        drive_t d;
        d = '0;
        case (op)
            OP_START: begin
                d.sda_low = 1'b1;
                d.scl_low = step[0];
            end
            OP_RESTART: begin
                d.scl_low = (step[1:0] == 2'd0) || (step[1:0] == 2'd3);
                d.sda_low = step[1];
            end
            OP_STOP: begin
                d.scl_low = (step[1:0] == 2'd0);
                d.sda_low = (step[1:0] != 2'd2);
            end
            OP_TX: begin
                d.scl_low = ~step[0];
                d.sda_low = step[4] ? 1'b0 : ~sh[3'd7 - step[3:1]];
            end
            OP_RX: begin
                d.scl_low = ~step[0];
                d.sda_low = 1'b0;
            end
            OP_ACK: begin
                d.scl_low = ~step[0];
                d.sda_low = ~ackv;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2cm_baud.sv
module i2cm_baud #(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [BAUD_W-1:0] reload,
    output logic              tick
);
    logic [BAUD_W-1:0] cnt;

    assign tick = run && (cnt == reload);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // R2: the detector needs a few clocks of each half-period
    assert_reload_floor_R2: assert property (@(posedge clk) disable iff (rst)
        run |-> (reload >= BAUD_W'(3)));

endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic                   sda_prev, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            sda_prev <= sda_s;
        end
    end

    assign scl_s     = scl_sync[SYNC_STAGES-1];
    assign sda_s     = sda_sync[SYNC_STAGES-1];
    assign start_det = scl_s && sda_prev && !sda_s;
    assign stop_det  = scl_s && !sda_prev && sda_s;

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bus_free,
    input  logic              tick,
    input  logic              cmd_start,
    input  logic              cmd_restart,
    input  logic              cmd_stop,
    input  logic              cmd_rx,
    input  logic              cmd_ack,
    input  logic              ack_nack,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              sda_s,
    output op_e               op,
    output logic              run,
    output logic              done,
    output logic              scl_low,
    output logic              sda_low,
    output logic              wcol_evt,
    output logic              ack_status,
    output logic [BYTE_W-1:0] rx_data
);
    logic [STEP_W-1:0] step;
    logic [BYTE_W-1:0] sh, rx_sh;
    logic              ackv;
    drive_t            hold, cur;
    op_e               next_op;

    assign run      = (op != OP_IDLE);
    assign done     = run && tick && (step == op_last_step(op));
    assign cur      = run ? op_drive(op, step, sh, ackv) : hold;
    assign scl_low  = cur.scl_low;
    assign sda_low  = cur.sda_low;
    assign wcol_evt = enable && tx_wr && (next_op != OP_TX);

    // single-slot command acceptance, fixed priority
    always_comb begin
        next_op = OP_IDLE;
        if (enable && !run) begin
            if (cmd_start && bus_free) next_op = OP_START;
            else if (cmd_restart)      next_op = OP_RESTART;
            else if (cmd_stop)         next_op = OP_STOP;
            else if (tx_wr)            next_op = OP_TX;
            else if (cmd_rx)           next_op = OP_RX;
            else if (cmd_ack)          next_op = OP_ACK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            op   <= OP_IDLE;
            step <= '0;
            hold <= '0;
        end else if (!run) begin
            op   <= next_op;
            step <= '0;
        end else if (tick) begin
            if (done) begin
                op   <= OP_IDLE;
                hold <= cur;
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh         <= '0;
            rx_sh      <= '0;
            rx_data    <= '0;
            ackv       <= 1'b0;
            ack_status <= 1'b0;
        end else begin
            if (next_op == OP_TX)  sh   <= tx_data;
            if (next_op == OP_ACK) ackv <= ack_nack;
            if (run && tick) begin
                if (op == OP_TX && step == op_last_step(OP_TX))
                    ack_status <= sda_s;
                if (op == OP_RX && step[0]) begin
                    rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                    if (done) rx_data <= {rx_sh[BYTE_W-2:0], sda_s};
                end
            end
        end
    end

    // R4: during data clocks SDA holds while SCL stays high
    assert_sda_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (run && (op == OP_TX || op == OP_RX || op == OP_ACK) && $past(run)
         && ($past(op) == op) && !scl_low && !$past(scl_low))
        |-> $stable(sda_low));

    // R9: no new operation is taken while one is running
    assert_single_op_R9: assert property (@(posedge clk) disable iff (rst)
        (run && !done && enable) |=> (op == $past(op)));

endmodule

// File: rtl/i2c_master_ctrl.sv
module i2c_master_ctrl
    import i2cm_pkg::*;
#(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              cmd_start,
    input  logic              cmd_restart,
    input  logic              cmd_stop,
    input  logic              cmd_rx,
    input  logic              cmd_ack,
    input  logic              ack_nack,
    input  logic              tx_wr,
    input  logic [7:0]        tx_data,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              irq,
    output logic              wcol,
    output logic              ack_status,
    output logic [7:0]        rx_data,
    output logic              start_seen,
    output logic              stop_seen
);
    logic tick, run, done, wcol_evt, sda_s, start_det, stop_det, suspend;
    op_e  op;

    i2cm_baud #(.BAUD_W(BAUD_W)) u_baud (
        .clk(clk), .rst(rst), .run(run), .reload(baud_reload), .tick(tick)
    );

    i2cm_busmon #(.SYNC_STAGES(2)) u_mon (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst(rst), .enable(enable),
        .bus_free(stop_seen || !start_seen), .tick(tick),
        .cmd_start(cmd_start), .cmd_restart(cmd_restart), .cmd_stop(cmd_stop),
        .cmd_rx(cmd_rx), .cmd_ack(cmd_ack), .ack_nack(ack_nack),
        .tx_wr(tx_wr), .tx_data(tx_data), .sda_s(sda_s),
        .op(op), .run(run), .done(done),
        .scl_low(scl_oe), .sda_low(sda_oe), .wcol_evt(wcol_evt),
        .ack_status(ack_status), .rx_data(rx_data)
    );

    assign busy    = run;
    assign suspend = (op == OP_START) || (op == OP_RESTART) || (op == OP_STOP);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else if (done && (op == OP_START || op == OP_RESTART)) begin
            start_seen <= 1'b1;
            stop_seen  <= 1'b0;
        end else if (done && op == OP_STOP) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b1;
        end else if (!suspend && start_det) begin
            start_seen <= 1'b1;
            stop_seen  <= 1'b0;
        end else if (!suspend && stop_det) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq  <= 1'b0;
            wcol <= 1'b0;
        end else begin
            if (done)         irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
            if (wcol_evt)      wcol <= 1'b1;
            else if (wcol_clr) wcol <= 1'b0;
        end
    end

    assert_irq_on_done_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && enable) |-> irq);

    assert_wcol_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && busy && enable) |=> wcol);

    assert_status_clear_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!start_seen && !stop_seen && !busy));

    assert_status_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_seen, stop_seen}));

endmodule

// File: tb/i2c_master_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_master_ctrl_bench;
    logic clk = 0, rst = 1, enable = 0;
    logic [7:0] baud_reload = 8'd4;
    logic cmd_start = 0, cmd_restart = 0, cmd_stop = 0, cmd_rx = 0, cmd_ack = 0;
    logic ack_nack = 0, tx_wr = 0, irq_clr = 0, wcol_clr = 0;
    logic [7:0] tx_data = 0;
    logic scl_oe, sda_oe, busy, irq, wcol, ack_status, start_seen, stop_seen;
    logic [7:0] rx_data;
    logic ext_sda = 0, s_drv = 0;
    logic scl_w, sda_w;

    int n_checks = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    assign scl_w = ~scl_oe;
    assign sda_w = ~(sda_oe | ext_sda | s_drv);

    i2c_master_ctrl u_i2c_master_ctrl (
        .clk(clk), .rst(rst), .enable(enable), .baud_reload(baud_reload),
        .cmd_start(cmd_start), .cmd_restart(cmd_restart), .cmd_stop(cmd_stop),
        .cmd_rx(cmd_rx), .cmd_ack(cmd_ack), .ack_nack(ack_nack),
        .tx_wr(tx_wr), .tx_data(tx_data), .irq_clr(irq_clr), .wcol_clr(wcol_clr),
        .scl_in(scl_w), .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .irq(irq), .wcol(wcol), .ack_status(ack_status),
        .rx_data(rx_data), .start_seen(start_seen), .stop_seen(stop_seen)
    );

    // ---------------- slave model, sampled between clock edges ----------------
    logic       s_ack_en = 1;
    logic [7:0] rd_src [0:1];
    logic [7:0] cap [0:15];
    int n_cap = 0, n_start = 0, n_stop = 0;
    int bitcnt = 0, rd_idx = 0;
    logic p_scl = 1, p_sda = 1, first = 0, reading = 0, rw = 0, mack = 1;
    logic [7:0] sh = 0, cur = 0;

    always @(negedge clk) begin
        if (scl_w && p_scl && (sda_w != p_sda)) begin
            if (!sda_w) begin
                n_start++; bitcnt = 0; first = 1; reading = 0; s_drv = 0; rd_idx = 0;
            end else begin
                n_stop++; bitcnt = 0; reading = 0; s_drv = 0;
            end
        end else if (scl_w && !p_scl) begin
            bitcnt++;
            if (bitcnt <= 8) sh = {sh[6:0], sda_w};
            else mack = sda_w;
        end else if (!scl_w && p_scl) begin
            if (bitcnt == 8) begin
                if (!reading) begin
                    cap[n_cap[3:0]] = sh; n_cap++;
                    if (first) rw = sh[0];
                    s_drv = s_ack_en;
                end else s_drv = 0;
            end else if (bitcnt == 9) begin
                bitcnt = 0; s_drv = 0;
                if (first) begin first = 0; reading = rw; end
                else if (reading && mack) reading = 0;
                if (reading) begin
                    cur = rd_src[rd_idx[0]]; rd_idx++; s_drv = ~cur[7];
                end
            end else if (reading && bitcnt >= 1 && bitcnt <= 7) begin
                s_drv = ~cur[3'(7 - bitcnt)];
            end
        end
        p_scl = scl_w;
        p_sda = sda_w;
    end

    // SCL half-period measurement
    int hi_cnt = 0, lo_cnt = 0, hi_len = 0, lo_len = 0;
    logic m_scl = 1;
    always @(posedge clk) begin
        if (scl_w) begin
            if (!m_scl) begin lo_len <= lo_cnt; hi_cnt <= 1; end
            else hi_cnt <= hi_cnt + 1;
        end else begin
            if (m_scl) begin hi_len <= hi_cnt; lo_cnt <= 1; end
            else lo_cnt <= lo_cnt + 1;
        end
        m_scl <= scl_w;
    end

    // ---------------- helpers ----------------
    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic cmd(input int k);
        @(negedge clk);
        case (k)
            0: cmd_start = 1;
            1: cmd_restart = 1;
            2: cmd_stop = 1;
            3: cmd_rx = 1;
            4: cmd_ack = 1;
            5: irq_clr = 1;
            default: wcol_clr = 1;
        endcase
        @(negedge clk);
        {cmd_start, cmd_restart, cmd_stop, cmd_rx, cmd_ack, irq_clr, wcol_clr} = '0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_wr = 1;
        @(negedge clk); tx_wr = 0;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    // run one command to completion and check irq rises with it
    task automatic op_cmd(input int k, input string req);
        cmd(5);
        cmd(k);
        wait_idle;
        check(irq === 1'b1, req, irq, 1);
    endtask

    task automatic op_send(input logic [7:0] b, input string req);
        cmd(5);
        send(b);
        wait_idle;
        check(irq === 1'b1, req, irq, 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        check(scl_oe === 0 && sda_oe === 0, "R1 lines released", {scl_oe, sda_oe}, 0);
        check(busy === 0 && irq === 0 && wcol === 0, "R1 flags", {busy, irq, wcol}, 0);
        check(start_seen === 0 && stop_seen === 0, "R1 status", {start_seen, stop_seen}, 0);
    endtask

    task automatic t_write7;
        int st0, sp0, c0, hcnt;
        st0 = n_start; sp0 = n_stop; c0 = n_cap;
        cmd(5);
        cmd(0);
        check(sda_w === 0 && scl_w === 1, "R3 sda falls first", {scl_w, sda_w}, 2'b10);
        hcnt = 0;
        while (scl_w && hcnt < 100) begin hcnt++; @(negedge clk); end
        check(hcnt == 5, "R3 start hold", hcnt, 5);
        wait_idle;
        check(irq === 1, "R3 irq", irq, 1);
        check(start_seen === 1 && stop_seen === 0, "R3 status", {start_seen, stop_seen}, 2'b10);
        cmd(5);
        check(irq === 0, "R10 irq cleared", irq, 0);
        op_send(8'hA0, "R4 irq addr");
        check(ack_status === 0, "R4 ack", ack_status, 0);
        check(hi_len == 5, "R2 high half", hi_len, 5);
        check(lo_len == 5, "R2 low half", lo_len, 5);
        op_send(8'h5A, "R4 irq data");
        op_cmd(2, "R8 irq");
        check(stop_seen === 1 && start_seen === 0, "R8 status", {start_seen, stop_seen}, 2'b01);
        check(cap[c0[3:0]] == 8'hA0 && cap[4'(c0 + 1)] == 8'h5A, "R4 bytes",
              cap[4'(c0 + 1)], 8'h5A);
        check(n_start - st0 == 1 && n_stop - sp0 == 1, "R4 no stray conditions",
              (n_start - st0) * 16 + (n_stop - sp0), 8'h11);
        // slave does not answer
        s_ack_en = 0;
        op_cmd(0, "R3 irq");
        op_send(8'h90, "R4 irq nack");
        check(ack_status === 1, "R4 nack", ack_status, 1);
        op_cmd(2, "R8 irq");
        s_ack_en = 1;
    endtask

    task automatic t_collision;
        int c0;
        c0 = n_cap;
        cmd(6);
        cmd(0);
        send(8'h11);
        check(wcol === 1, "R9 wcol during start", wcol, 1);
        wait_idle;
        repeat (20) @(negedge clk);
        check(busy === 0 && n_cap == c0, "R9 nothing queued", n_cap - c0, 0);
        cmd(6);
        check(wcol === 0, "R10 wcol cleared", wcol, 0);
        send(8'hA0);
        repeat (10) @(negedge clk);
        send(8'h00);
        cmd(2);
        wait_idle;
        repeat (20) @(negedge clk);
        check(wcol === 1, "R9 wcol during byte", wcol, 1);
        check(cap[c0[3:0]] == 8'hA0 && n_cap == c0 + 1, "R9 byte intact", cap[c0[3:0]], 8'hA0);
        check(start_seen === 1 && stop_seen === 0, "R9 stop ignored while busy",
              {start_seen, stop_seen}, 2'b10);
        op_cmd(2, "R8 irq");
        cmd(6);
    endtask

    task automatic t_read7;
        int sp0;
        rd_src[0] = 8'hA5; rd_src[1] = 8'h3C;
        op_cmd(0, "R3 irq");
        op_send(8'hA1, "R4 irq");
        op_cmd(3, "R5 irq");
        check(rx_data == 8'hA5, "R5 first byte", rx_data, 8'hA5);
        ack_nack = 0;
        op_cmd(4, "R6 irq");
        check(mack === 0, "R6 ack low", mack, 0);
        op_cmd(3, "R5 irq");
        check(rx_data == 8'h3C, "R5 second byte", rx_data, 8'h3C);
        ack_nack = 1;
        op_cmd(4, "R6 irq");
        check(mack === 1, "R6 nack released", mack, 1);
        sp0 = n_stop;
        op_cmd(2, "R8 irq");
        check(n_stop == sp0 + 1 && stop_seen === 1, "R8 stop on bus", n_stop - sp0, 1);
    endtask

    task automatic t_read10;
        int c0, sp0;
        c0 = n_cap; sp0 = n_stop;
        rd_src[0] = 8'h96;
        op_cmd(0, "R3 irq");
        op_send(8'hF2, "R4 irq");
        op_send(8'h34, "R4 irq");
        op_cmd(1, "R7 irq");
        check(start_seen === 1 && stop_seen === 0, "R7 status", {start_seen, stop_seen}, 2'b10);
        check(n_stop == sp0, "R7 no stop", n_stop - sp0, 0);
        op_send(8'hF3, "R4 irq");
        op_cmd(3, "R5 irq");
        check(rx_data == 8'h96, "R5 10-bit read", rx_data, 8'h96);
        ack_nack = 1;
        op_cmd(4, "R6 irq");
        op_cmd(2, "R8 irq");
        check(cap[c0[3:0]] == 8'hF2 && cap[4'(c0 + 1)] == 8'h34 && cap[4'(c0 + 2)] == 8'hF3,
              "R7 address bytes", cap[4'(c0 + 2)], 8'hF3);
    endtask

    task automatic t_bus_owned;
        @(negedge clk); ext_sda = 1;
        repeat (6) @(negedge clk);
        check(start_seen === 1 && stop_seen === 0, "R11 external start", {start_seen, stop_seen}, 2'b10);
        cmd(0);
        check(busy === 0, "R11 start refused", busy, 0);
        ext_sda = 0;
        repeat (6) @(negedge clk);
        check(stop_seen === 1 && start_seen === 0, "R11 external stop", {start_seen, stop_seen}, 2'b01);
        baud_reload = 8'd7;
        cmd(0);
        check(busy === 1, "R11 start taken", busy, 1);
        wait_idle;
        op_send(8'h00, "R4 irq");
        check(hi_len == 8, "R2 other reload", hi_len, 8);
        op_cmd(2, "R8 irq");
        baud_reload = 8'd4;
    endtask

    task automatic t_disable;
        op_cmd(0, "R3 irq");
        @(negedge clk); enable = 0;
        repeat (2) @(negedge clk);
        check(scl_oe === 0 && sda_oe === 0 && busy === 0, "R1 disable releases",
              {scl_oe, sda_oe, busy}, 0);
        check(start_seen === 0 && stop_seen === 0, "R1 disable clears status",
              {start_seen, stop_seen}, 0);
        cmd(0);
        check(busy === 0 && sda_oe === 0, "R1 commands ignored", busy, 0);
        enable = 1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        enable = 1;
        repeat (5) @(negedge clk);
        t_write7;
        t_collision;
        t_read7;
        t_read10;
        t_bus_owned;
        t_disable;
        finish_run;
    end

endmodule